// File: doc/BRIEF.md
# Latchable Parity Transceiver

This block connects two 8-bit data buses, called side A and side B. Each bus carries its own parity bit. Data crosses the block in one direction at a time. Two active-low drive enables choose the direction: one lets side A drive side B, the other lets side B drive side A. Each side has a latch between its bus and the internal datapath. The latch is transparent while its enable is high. While the enable is low, the latch holds the byte and parity it last captured.

A shared mode line decides the outgoing parity. In generate mode the block computes parity from the source byte. In feed-through mode it forwards the source parity unchanged. A second line picks even or odd parity. Both sides check parity all the time and report a mismatch on an active-low error flag. The latch on the driven side can also be transparent. It then sees the value the block itself drives, so its error flag checks that outgoing word while the source flag checks the incoming one.

Tri-state pins are split into separate input, output and output-enable signals. The latch storage is clocked: a closed latch holds the value that was present at the last rising clock edge while its enable was high. A synchronous active-high reset clears that stored value to zero.

Top module: `lpx_transceiver`

## Requirements
- R1: With `oe_ab_n`=0 and `oe_ba_n`=1, `b_oe` is 1, `a_oe` is 0, and `b_out` equals the data seen through the A latch. With `oe_ba_n`=0 and `oe_ab_n`=1, the roles of the two sides swap.
- R2: When both drive enables are 1 (idle), or both are 0 (a clash, treated as illegal), `a_oe` and `b_oe` are both 0.
- R3: With `pass_sel`=0 (generate), the driven parity bit makes the total count of ones across the 9 driven bits even when `odd_sel`=0, and odd when `odd_sel`=1.
- R4: With `pass_sel`=1 (feed-through), the driven parity bit equals the parity bit seen through the source latch.
- R5: A latch whose enable is 1 passes its bus value through in the same cycle. While its enable is 0, it presents the value captured at the last rising clock edge at which its enable was 1. Reset clears that stored value to all zeros.
- R6: `err_a_n` is 0 exactly when the parity bit seen through the A latch differs from the parity computed from the data seen through that latch, under the current `odd_sel`. This holds in both generate and feed-through modes. `err_b_n` follows the same rule for side B.
- R7: While the destination latch is transparent, its flag checks the driven word. In generate mode that flag therefore stays 1. In feed-through mode it equals the source flag.
- R8: While the source latch is closed, the driven data, the driven parity and the source error flag all come from the held contents and ignore the live source bus.
- R9: While the destination latch is closed, the destination flag reflects that latch's held contents, not the driven word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch storage |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Data received from side A |
| a_par_in | input | 1 | Parity received from side A |
| a_out | output | 8 | Data driven onto side A |
| a_par_out | output | 1 | Parity driven onto side A |
| a_oe | output | 1 | High while the block drives side A |
| b_in | input | 8 | Data received from side B |
| b_par_in | input | 1 | Parity received from side B |
| b_out | output | 8 | Data driven onto side B |
| b_par_out | output | 1 | Parity driven onto side B |
| b_oe | output | 1 | High while the block drives side B |
| oe_ab_n | input | 1 | Active-low enable for driving side B from side A |
| oe_ba_n | input | 1 | Active-low enable for driving side A from side B |
| pass_sel | input | 1 | 0 = generate parity, 1 = feed parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| le_a | input | 1 | A latch enable, 1 = transparent |
| le_b | input | 1 | B latch enable, 1 = transparent |
| err_a_n | output | 1 | Active-low parity error flag for side A |
| err_b_n | output | 1 | Active-low parity error flag for side B |

## Verification
Every output is combinational from the inputs and the latch storage, so each result is due in the same cycle as the stimulus that causes it. The driver applies a vector on the falling edge and queues the expected outputs at once. The monitor checks them 5 ns later, before the next rising edge. The rising edge after a vector stores any open latch's value, and that stored value only shows up in the next vector's expectations. The bench's own model updates its copy of the stored state in the same order.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

    localparam int DATA_W  = 8;
    localparam int N_SIDES = 2;
    localparam int SIDE_A  = 0;
    localparam int SIDE_B  = 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
    } lane_t;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_A2B   = 2'd1,
        DIR_B2A   = 2'd2,
        DIR_CLASH = 2'd3
    } dir_e;

    // Parity bit that makes the total ones count even (odd=0) or odd (odd=1)
    function automatic logic gen_par(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic dir_e decode_dir(input logic ab_n, input logic ba_n);
        dir_e r;
        case ({ab_n, ba_n})
            2'b01:   r = DIR_A2B;
            2'b10:   r = DIR_B2A;
            2'b00:   r = DIR_CLASH;
            default: r = DIR_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lpx_latch.sv
module lpx_latch
    import lpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  le,
    input  lane_t d_live,
    input  lane_t d_bus,
    output lane_t q_src,
    output lane_t q_bus
);

    lane_t held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (le)
            held <= d_bus;
    end

    always_comb begin
        q_src = le ? d_live : held;
        q_bus = le ? d_bus  : held;
    end

    // R5: a latch closed for two cycles in a row presents an unchanged value
    a_r5_closed_holds: assert property (@(posedge clk) disable iff (rst)
        (!le && !$past(le)) |-> $stable(q_bus));

endmodule

// File: rtl/lpx_drive.sv
module lpx_drive
    import lpx_pkg::*;
(
    input  lane_t src,
    input  logic  pass_sel,
    input  logic  odd_sel,
    output lane_t drv
);

    always_comb begin
        drv.data = src.data;
        drv.par  = pass_sel ? src.par : gen_par(src.data, odd_sel);
    end

endmodule

// File: rtl/lpx_check.sv
module lpx_check
    import lpx_pkg::*;
(
    input  lane_t q,
    input  logic  odd_sel,
    output logic  err_n
);

    always_comb err_n = ~(gen_par(q.data, odd_sel) ^ q.par);

endmodule

// File: rtl/lpx_transceiver.sv
module lpx_transceiver
    import lpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic              a_par_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_par_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_par_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_par_out,
    output logic              b_oe,
    input  logic              oe_ab_n,
    input  logic              oe_ba_n,
    input  logic              pass_sel,
    input  logic              odd_sel,
    input  logic              le_a,
    input  logic              le_b,
    output logic              err_a_n,
    output logic              err_b_n
);

    dir_e  dir;
    lane_t live [N_SIDES];
    lane_t src  [N_SIDES];
    lane_t drv  [N_SIDES];
    lane_t bus  [N_SIDES];
    lane_t q    [N_SIDES];
    logic  le   [N_SIDES];
    logic  den  [N_SIDES];
    logic  errn [N_SIDES];

    always_comb begin
        dir          = decode_dir(oe_ab_n, oe_ba_n);
        live[SIDE_A] = '{data: a_in, par: a_par_in};
        live[SIDE_B] = '{data: b_in, par: b_par_in};
        le[SIDE_A]   = le_a;
        le[SIDE_B]   = le_b;
        den[SIDE_A]  = (dir == DIR_B2A);
        den[SIDE_B]  = (dir == DIR_A2B);
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        // side s drives a word built from the opposite side's source view
        lpx_drive u_drive (
            .src      (src[N_SIDES-1-s]),
            .pass_sel (pass_sel),
            .odd_sel  (odd_sel),
            .drv      (drv[s])
        );

        always_comb bus[s] = den[s] ? drv[s] : live[s];

        lpx_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .le     (le[s]),
            .d_live (live[s]),
            .d_bus  (bus[s]),
            .q_src  (src[s]),
            .q_bus  (q[s])
        );

        lpx_check u_check (
            .q       (q[s]),
            .odd_sel (odd_sel),
            .err_n   (errn[s])
        );
    end

    always_comb begin
        a_out     = drv[SIDE_A].data;
        a_par_out = drv[SIDE_A].par;
        a_oe      = den[SIDE_A];
        b_out     = drv[SIDE_B].data;
        b_par_out = drv[SIDE_B].par;
        b_oe      = den[SIDE_B];
        err_a_n   = errn[SIDE_A];
        err_b_n   = errn[SIDE_B];
    end

    // R1: an open A latch passes A data straight onto B
    a_r1_b_follows_a: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && oe_ba_n && le_a) |-> (b_oe && b_out == a_in));

    // R2: never both sides driven; idle drives nothing
    a_r2_single_driver: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (oe_ab_n == oe_ba_n) |-> (!a_oe && !b_oe));

    // R3: generated word carries the selected total parity
    a_r3_gen_word: assert property (@(posedge clk) disable iff (rst)
        (b_oe && !pass_sel) |-> ((^{b_out, b_par_out}) == odd_sel));

    // R4: feed-through forwards the incoming parity bit
    a_r4_feed_par: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && oe_ba_n && pass_sel && le_a) |-> (b_par_out == a_par_in));

    // R6: source flag tracks the live A word when A latch is open
    a_r6_src_flag: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && oe_ba_n && le_a) |-> (err_a_n == ((^{a_in, a_par_in}) == odd_sel)));

    // R7: loopback through the open destination latch
    a_r7_gen_loop: assert property (@(posedge clk) disable iff (rst)
        (!oe_ba_n && oe_ab_n && !pass_sel && le_a) |-> err_a_n);
    a_r7_feed_mirror: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && oe_ba_n && pass_sel && le_b) |-> (err_b_n == err_a_n));

    // R8: closed source latch keeps the driven word steady
    a_r8_src_hold: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab_n && oe_ba_n && !le_a && !$past(le_a) &&
         $stable(pass_sel) && $stable(odd_sel) && $past(!oe_ab_n && oe_ba_n))
        |-> ($stable(b_out) && $stable(b_par_out)));

endmodule

// File: tb/sim_lpx_transceiver.sv
`timescale 1ns/1ps
module sim_lpx_transceiver;

    typedef struct packed {
        logic [7:0] d;
        logic       p;
    } word_t;

    typedef struct packed {
        logic       dab, dba, pass, lea, leb;
        logic       a_oe, b_oe;
        word_t      a_w, b_w;
        logic       ea, eb;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic       a_par_in = 1'b0, b_par_in = 1'b0;
    logic [7:0] a_out, b_out;
    logic       a_par_out, b_par_out, a_oe, b_oe;
    logic       oe_ab_n = 1'b1, oe_ba_n = 1'b1;
    logic       pass_sel = 1'b0, odd_sel = 1'b0, le_a = 1'b0, le_b = 1'b0;
    logic       err_a_n, err_b_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 1'b0;
    exp_t  sb [$];
    word_t hA = '0, hB = '0;

    always #10 clk = ~clk;

    lpx_transceiver u0 (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .pass_sel(pass_sel), .odd_sel(odd_sel),
        .le_a(le_a), .le_b(le_b), .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    function automatic logic mpar(input logic [7:0] d, input logic odd);
        return logic'($countones(d) % 2) ^ odd;
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver: applies a vector and pushes its expected outputs
    task automatic drive(input logic ab_n, input logic ba_n, input logic ps, input logic od,
                         input logic la, input logic lb, input word_t wa, input word_t wb);
        word_t sA, sB, dA, dB, busA, busB, qa, qb;
        exp_t  e;
        @(negedge clk);
        oe_ab_n = ab_n; oe_ba_n = ba_n; pass_sel = ps; odd_sel = od;
        le_a = la; le_b = lb;
        a_in = wa.d; a_par_in = wa.p; b_in = wb.d; b_par_in = wb.p;
        e.dab = !ab_n && ba_n;
        e.dba = ab_n && !ba_n;
        sA = la ? wa : hA;
        sB = lb ? wb : hB;
        dB = '{d: sA.d, p: ps ? sA.p : mpar(sA.d, od)};
        dA = '{d: sB.d, p: ps ? sB.p : mpar(sB.d, od)};
        busA = e.dba ? dA : wa;
        busB = e.dab ? dB : wb;
        qa = la ? busA : hA;
        qb = lb ? busB : hB;
        e.pass = ps; e.lea = la; e.leb = lb;
        e.a_oe = e.dba; e.b_oe = e.dab;
        e.a_w = dA; e.b_w = dB;
        e.ea = (mpar(qa.d, od) == qa.p);
        e.eb = (mpar(qb.d, od) == qb.p);
        sb.push_back(e);
        if (la) hA = busA;
        if (lb) hB = busB;
    endtask

    // Monitor: pops and compares 5 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                string tdat, tpar, tdst;
                e = sb.pop_front();
                chk((e.dab || e.dba) ? "R1 oe" : "R2 oe", {7'd0, a_oe, b_oe}, {7'd0, e.a_oe, e.b_oe});
                tpar = e.pass ? "R4 par" : "R3 par";
                if (e.dab) begin
                    tdat = e.lea ? "R1 data" : "R8 data";
                    tdst = e.leb ? "R7 dst flag" : "R9 dst flag";
                    chk(tdat, {b_out, 1'b0}, {e.b_w.d, 1'b0});
                    chk(tpar, {8'd0, b_par_out}, {8'd0, e.b_w.p});
                    chk(e.lea ? "R6 src flag" : "R8 src flag", {8'd0, err_a_n}, {8'd0, e.ea});
                    chk(tdst, {8'd0, err_b_n}, {8'd0, e.eb});
                end else if (e.dba) begin
                    tdat = e.leb ? "R1 data" : "R8 data";
                    tdst = e.lea ? "R7 dst flag" : "R9 dst flag";
                    chk(tdat, {a_out, 1'b0}, {e.a_w.d, 1'b0});
                    chk(tpar, {8'd0, a_par_out}, {8'd0, e.a_w.p});
                    chk(e.leb ? "R6 src flag" : "R8 src flag", {8'd0, err_b_n}, {8'd0, e.eb});
                    chk(tdst, {8'd0, err_a_n}, {8'd0, e.ea});
                end else begin
                    chk("R6 flags", {7'd0, err_a_n, err_b_n}, {7'd0, e.ea, e.eb});
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=50000", cycles);
                finish_up();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // R5: reset leaves zero storage, so both closed latches show a clean even word
        chk("R5 reset flags", {7'd0, err_a_n, err_b_n}, 9'h003);
        chk("R5 reset oe", {7'd0, a_oe, b_oe}, 9'h000);

        // Directed hold: capture 0xA5 on A, then close and change the bus (R5, R8)
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '{d: 8'hA5, p: 1'b0}, '{d: 8'h00, p: 1'b0});
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '{d: 8'h3C, p: 1'b1}, '{d: 8'h00, p: 1'b0});
        @(negedge clk); #6;
        chk("R5 held byte", {b_out, 1'b0}, {8'hA5, 1'b0});

        // Directed clash and idle (R2)
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '{d: 8'h01, p: 1'b0}, '{d: 8'h02, p: 1'b1});
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '{d: 8'h07, p: 1'b0}, '{d: 8'hFF, p: 1'b1});

        // Sweep every mode row with random words, several passes
        for (int rep = 0; rep < 6; rep++) begin
            for (int v = 0; v < 64; v++) begin
                logic [5:0] c;
                word_t wa, wb;
                c = 6'(v);
                wa = '{d: 8'($urandom), p: 1'($urandom)};
                wb = '{d: 8'($urandom), p: 1'($urandom)};
                drive(c[5] ^ c[4] ? c[5] : 1'b1, c[5] ^ c[4] ? c[4] : 1'b1,
                      c[3], c[2], c[1], c[0], wa, wb);
            end
        end

        repeat (4) @(negedge clk);
        #8;
        done = 1'b1;
        finish_up();
    end

endmodule